// File: doc/BRIEF.md
# Elementary Cellular Automaton Engine

This block grows a one-dimensional row of binary cells, one generation per clock cycle. A cell is live when it holds 1 and dead when it holds 0. Every cell of the next generation is looked up in an 8-bit rule word, indexed by the cell and its two immediate neighbours in the current generation. Two well-known rules, 30 and 150, are built in as presets. A third choice takes any rule word from an input port.

A run begins with a start pulse. The block loads a row that holds a single live cell at the centre position. It presents that seed row first, then each further generation in turn, as a parallel word with a one-cycle valid strobe. When the requested number of generations has been shown, the block raises a done flag. The rule choice and the generation count are captured when the run starts. The usual run length is 64 generations after the seed.

Top module: `eca_engine`

## Requirements
- R1: After reset, rowValid and done are both 0.
- R2: When start is high on a clock edge while the block is idle, rowValid is 1 in the following cycle, and rowData holds exactly one live cell, at index WIDTH/2.
- R3: Bit 0 of rowData is the rightmost cell and bit WIDTH-1 the leftmost. Cell i of each new generation equals bit k of the active rule, where k is the 3-bit value {row[i+1], row[i], row[i-1]} of the previous generation.
- R4: Any neighbour lying outside the row (above index WIDTH-1 or below index 0) counts as a dead cell.
- R5: The rule is selected by ruleSel: 2'b00 selects rule 30, 2'b01 selects rule 150, and 2'b10 or 2'b11 selects the value on ruleCustom.
- R6: For a captured genCount of N, rowValid is high for exactly N+1 consecutive cycles: first the seed row, then one new generation per cycle. After that it drops to 0.
- R7: done becomes 1 in the cycle after the last valid row and stays 1 until the next accepted start. It is 0 during a run and is never high together with rowValid.
- R8: ruleSel, ruleCustom and genCount are sampled only on an accepted start. A start pulse during an active run, or a change on those inputs during a run, has no effect on the rows or on the run length.
- R9: A genCount of 0 produces only the seed row, and done follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when the block is idle |
| ruleSel | input | 2 | Rule choice: 30, 150 or custom |
| ruleCustom | input | 8 | Rule word used when ruleSel is 2 or 3 |
| genCount | input | GEN_W | Number of generations after the seed |
| rowData | output | WIDTH | Current generation; bit 0 is the rightmost cell |
| rowValid | output | 1 | High for one cycle per presented generation |
| done | output | 1 | Run complete; held until the next start |

## Verification
The seed row appears one cycle after the edge that accepts start. Generation g appears g cycles after that, and done rises one cycle after generation N. The bench drives its inputs on the falling edge. After a start pulse it samples on each later falling edge, so that sample k is compared with a reference generation k computed in the bench from the rule bits. One extra sample after the last row checks that rowValid has dropped and done has risen. Runs longer than half the row width exercise the dead boundary. A run with a second start pulse and altered select inputs partway through checks that the sequence and the length do not change.

// File: rtl/eca_pkg.sv
package eca_pkg;
  typedef struct packed {
    logic loadSeed;
    logic step;
  } eca_strobe_t;

  localparam logic [7:0] RULE_PRESET_A = 8'd30;
  localparam logic [7:0] RULE_PRESET_B = 8'd150;
endpackage

// File: rtl/eca_ctrl.sv
module eca_ctrl
  import eca_pkg::*;
#(
  parameter int GEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [GEN_W-1:0] genCount,
  output eca_strobe_t      strobe,
  output logic             rowValid,
  output logic             done
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t           state;
  logic [GEN_W-1:0] genIdx;
  logic [GEN_W-1:0] genTarget;

  always_comb begin
    strobe.loadSeed = (state == ST_IDLE) && start;
    strobe.step     = (state == ST_RUN) && (genIdx != genTarget);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      genIdx    <= '0;
      genTarget <= '0;
      rowValid  <= 1'b0;
      done      <= 1'b0;
    end else if (strobe.loadSeed) begin
      state     <= ST_RUN;
      genIdx    <= '0;
      genTarget <= genCount;
      rowValid  <= 1'b1;
      done      <= 1'b0;
    end else if (strobe.step) begin
      genIdx    <= genIdx + 1'b1;
      rowValid  <= 1'b1;
    end else if (state == ST_RUN) begin
      state     <= ST_IDLE;
      rowValid  <= 1'b0;
      done      <= 1'b1;
    end
  end

  assert_valid_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadSeed |=> (rowValid && !done));

  assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (genIdx <= genTarget));

  assert_done_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && rowValid));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && start) |=> $stable(genTarget));
endmodule

// File: rtl/eca_datapath.sv
module eca_datapath
  import eca_pkg::*;
#(
  parameter int WIDTH = 129
) (
  input  logic             clk,
  input  logic             rst_n,
  input  eca_strobe_t      strobe,
  input  logic [1:0]       ruleSel,
  input  logic [7:0]       ruleCustom,
  output logic [WIDTH-1:0] rowData
);
  localparam int SEED_IDX = WIDTH / 2;
  localparam logic [WIDTH-1:0] SEED_ROW = {{(WIDTH-1){1'b0}}, 1'b1} << SEED_IDX;

  logic [WIDTH-1:0] rowReg;
  logic [7:0]       ruleReg;
  logic [7:0]       ruleChosen;
  logic [WIDTH+1:0] padded;
  logic [WIDTH-1:0] nextRow;

  always_comb begin
    unique case (ruleSel)
      2'b00:   ruleChosen = RULE_PRESET_A;
      2'b01:   ruleChosen = RULE_PRESET_B;
      default: ruleChosen = ruleCustom;
    endcase
  end

  assign padded = {1'b0, rowReg, 1'b0};

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
    assign nextRow[gi] = ruleReg[padded[gi+2:gi]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rowReg  <= '0;
      ruleReg <= '0;
    end else if (strobe.loadSeed) begin
      rowReg  <= SEED_ROW;
      ruleReg <= ruleChosen;
    end else if (strobe.step) begin
      rowReg  <= nextRow;
    end
  end

  assign rowData = rowReg;

  assert_seed_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadSeed |=> ($countones(rowData) == 1 && rowData[SEED_IDX]));

  assert_rule_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadSeed |=> $stable(ruleReg));

  assert_row_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.loadSeed && !strobe.step) |=> $stable(rowData));
endmodule

// File: rtl/eca_engine.sv
module eca_engine
  import eca_pkg::*;
#(
  parameter int WIDTH = 129,
  parameter int GEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       ruleSel,
  input  logic [7:0]       ruleCustom,
  input  logic [GEN_W-1:0] genCount,
  output logic [WIDTH-1:0] rowData,
  output logic             rowValid,
  output logic             done
);
  eca_strobe_t strobe;

  eca_ctrl #(.GEN_W(GEN_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .genCount (genCount),
    .strobe   (strobe),
    .rowValid (rowValid),
    .done     (done)
  );

  eca_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .ruleSel    (ruleSel),
    .ruleCustom (ruleCustom),
    .rowData    (rowData)
  );
endmodule

// File: tb/tb_eca_engine.sv
`timescale 1ns/1ps
module tb_eca_engine;
  localparam int WIDTH = 129;
  localparam int GEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [1:0]       ruleSel = 2'b00;
  logic [7:0]       ruleCustom = 8'd0;
  logic [GEN_W-1:0] genCount = '0;
  logic [WIDTH-1:0] rowData;
  logic             rowValid;
  logic             done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  eca_engine #(.WIDTH(WIDTH), .GEN_W(GEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ruleSel(ruleSel),
    .ruleCustom(ruleCustom), .genCount(genCount),
    .rowData(rowData), .rowValid(rowValid), .done(done)
  );

  function automatic logic [WIDTH-1:0] refNext(input logic [WIDTH-1:0] row, input logic [7:0] rule);
    logic [WIDTH-1:0] res;
    for (int i = 0; i < WIDTH; i++) begin
      logic l, c, r;
      l = (i == WIDTH-1) ? 1'b0 : row[i+1];
      c = row[i];
      r = (i == 0) ? 1'b0 : row[i-1];
      res[i] = rule[{l, c, r}];
    end
    return res;
  endfunction

  task automatic check(input bit ok, input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(rowValid == 1'b0, "R1 rowValid", WIDTH'(rowValid), '0);
    check(done == 1'b0, "R1 done", WIDTH'(done), '0);
  endtask

  // One run; when disturb is set, a second start with altered inputs is applied at generation 2 (R8)
  task automatic runCheck(input logic [1:0] sel, input logic [7:0] custom, input logic [7:0] rule,
                          input int count, input bit disturb, input string tag);
    logic [WIDTH-1:0] model;
    model = '0;
    model[WIDTH/2] = 1'b1;
    ruleSel = sel;
    ruleCustom = custom;
    genCount = GEN_W'(count);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R7 done cleared on start", WIDTH'(done), '0);
    for (int g = 0; g <= count; g++) begin
      check(rowValid == 1'b1, {tag, " R6 valid"}, WIDTH'(rowValid), WIDTH'(1));
      check(rowData == model, {tag, (g == 0) ? " R2 seed" : " R3 R4 R5 row"}, rowData, model);
      if (g > 0) check(done == 1'b0, {tag, " R7 done low mid-run"}, WIDTH'(done), '0);
      model = refNext(model, rule);
      if (disturb && g == 2) begin
        start = 1'b1;
        ruleSel = ~sel;
        ruleCustom = ~custom;
        genCount = GEN_W'(count + 5);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(rowValid == 1'b0, {tag, " R6 valid drops"}, WIDTH'(rowValid), '0);
    check(done == 1'b1, {tag, " R7 done rises"}, WIDTH'(done), WIDTH'(1));
    @(negedge clk);
    check(done == 1'b1 && rowValid == 1'b0, {tag, " R7 done held"}, WIDTH'({rowValid, done}), WIDTH'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    runCheck(2'b00, 8'h00, 8'd30, 64, 1'b0, "rule30");
    runCheck(2'b01, 8'h00, 8'd150, 64, 1'b0, "rule150");
    runCheck(2'b10, 8'd90, 8'd90, 10, 1'b0, "custom90");
    runCheck(2'b11, 8'd1, 8'd1, 5, 1'b0, "custom1");
    runCheck(2'b00, 8'h00, 8'd30, 80, 1'b0, "boundary R4");
    runCheck(2'b01, 8'h00, 8'd150, 0, 1'b0, "zero R9");
    runCheck(2'b01, 8'h5A, 8'd150, 20, 1'b1, "ignore R8");
    finishUp();
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishUp();
  end
endmodule